// File: doc/BRIEF.md
# Dual-Mode I/O Window Address Translator

This block sits between a processor's memory-mapped I/O window and a legacy port-addressed bus. A request carries a 32-bit CPU address, a direction flag, an access size and write data. When the address falls inside an 8 MB window based at 0x80000000, the block forms a port address and flags a hit. The registered result appears one clock after the request.

Two layouts are supported, chosen by a map-mode input that is sampled with each request. In contiguous mode (0) the port is simply the low 16 address bits. In spread mode (1) each 4 KB CPU page holds one 32-byte port group. The page number is moved down next to the five low offset bits, and the address bits between them are dropped. Size, direction and data pass through untouched, so byte, halfword and word accesses all follow the same rule.

Top module: `io_window_xlate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid, out_hit, out_port, out_size, out_write and out_wdata are all zero.
- R2: out_valid in a cycle equals in_valid in the previous cycle (one register stage of latency).
- R3: out_hit is 1 exactly when the previous cycle carried a valid request with 0x80000000 <= in_addr < 0x80800000. A valid request outside that range gives out_hit 0 and out_port 0.
- R4: With map_mode 0 on a hitting request, out_port (20 bits) equals in_addr[15:0], zero-extended.
- R5: With map_mode 1 on a hitting request, out_port[4:0] = in_addr[4:0] and out_port[19:5] = in_addr[26:12].
- R6: With map_mode 1, in_addr[11:5] has no effect on out_port. Two addresses that differ only there give the same port.
- R7: On every valid request, out_size (2 bits: 0 byte, 1 halfword, 2 word), out_write and out_wdata repeat the request's values one cycle later, and the port rule does not depend on the size.
- R8: map_mode is sampled only together with a valid request. In cycles without a request, out_port, out_size, out_write and out_wdata hold their values, so a mode change never alters a result already presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_addr | input | 32 | CPU address |
| in_write | input | 1 | 1 for a write, 0 for a read |
| in_size | input | 2 | Access size code |
| in_wdata | input | 32 | Write data |
| map_mode | input | 1 | 0 contiguous layout, 1 spread layout |
| out_valid | output | 1 | Forwarded request present |
| out_hit | output | 1 | Request fell inside the window |
| out_port | output | 20 | Translated port address |
| out_write | output | 1 | Forwarded direction |
| out_size | output | 2 | Forwarded size |
| out_wdata | output | 32 | Forwarded write data |

## Verification
The bench goes after the window edges: the last byte 0x807FFFFF, the first byte past it 0x80800000, and 0x7FFFFFFF. A comparator off by one there would hit or miss at the wrong place. It sends pairs of spread-mode addresses that differ only in bits 11..5. A translator that kept those bits or shifted by the wrong amount would give two different ports. It also flips the mode in idle cycles right after a request. A design that decoded the mode combinationally at the output would change a result already shown. Random traffic in both modes, mixing all sizes and addresses inside and outside the window, is compared cycle by cycle against a behavioural model.

// File: rtl/io_window_xlate.sv
module io_window_xlate #(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
  parameter int          WIN_BITS  = 23,
  parameter int          FLAT_BITS = 16,
  parameter int          KEEP_BITS = 5,
  parameter int          PAGE_LSB  = 12,
  parameter int          PAGE_MSB  = 26,
  parameter int          SHIFT     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_addr,
  input  logic              in_write,
  input  logic [1:0]        in_size,
  input  logic [31:0]       in_wdata,
  input  logic              map_mode,
  output logic              out_valid,
  output logic              out_hit,
  output logic [19:0]       out_port,
  output logic              out_write,
  output logic [1:0]        out_size,
  output logic [31:0]       out_wdata
);
  localparam int PORT_W   = PAGE_MSB - SHIFT + 1;
  localparam int PAGE_W   = PAGE_MSB - PAGE_LSB + 1;
  localparam int TAG_W    = ADDR_W - WIN_BITS;

  logic              in_win;
  logic [PORT_W-1:0] flat_port, spread_port, next_port;

  assign in_win = (in_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

  assign flat_port   = PORT_W'(in_addr[FLAT_BITS-1:0]);
  assign spread_port = {in_addr[PAGE_MSB:PAGE_LSB], in_addr[KEEP_BITS-1:0]};

  generate
    if (PAGE_LSB - SHIFT == KEEP_BITS) begin : g_dense
      assign next_port = map_mode ? spread_port : flat_port;
    end else begin : g_sparse
      logic [PORT_W-1:0] shifted;
      assign shifted   = PORT_W'({in_addr[PAGE_MSB:PAGE_LSB], {PAGE_LSB{1'b0}}} >> SHIFT)
                       | PORT_W'(in_addr[KEEP_BITS-1:0]);
      assign next_port = map_mode ? shifted : flat_port;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_port  <= '0;
      out_write <= 1'b0;
      out_size  <= '0;
      out_wdata <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= in_valid && in_win;
      if (in_valid) begin
        out_port  <= in_win ? next_port : '0;
        out_write <= in_write;
        out_size  <= in_size;
        out_wdata <= in_wdata;
      end
    end
  end

  // R2
  vld_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R3
  hit_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid);
  // R3
  miss_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_win) |=> (!out_hit && out_port == '0));
  // R5
  spread_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_win && map_mode) |=> out_port[KEEP_BITS-1:0] == $past(in_addr[KEEP_BITS-1:0]));
  // R7
  fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_size == $past(in_size) && out_write == $past(in_write)
                  && out_wdata == $past(in_wdata)));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_port) && $stable(out_size) && $stable(out_write)
                   && $stable(out_wdata)));

  logic unused_tag;
  assign unused_tag = ^{TAG_W{1'b0}} ^ ^{PAGE_W{1'b0}} ^ ^{DATA_W{1'b0}};
endmodule

// File: tb/io_window_xlate_tb.sv
`timescale 1ns/1ps
module io_window_xlate_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [31:0] in_addr = 0;
  logic        in_write = 0;
  logic [1:0]  in_size = 0;
  logic [31:0] in_wdata = 0;
  logic        map_mode = 0;
  logic        out_valid, out_hit, out_write;
  logic [19:0] out_port;
  logic [1:0]  out_size;
  logic [31:0] out_wdata;

  always #4 clk = ~clk;

  io_window_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_write(in_write), .in_size(in_size), .in_wdata(in_wdata),
    .map_mode(map_mode), .out_valid(out_valid), .out_hit(out_hit),
    .out_port(out_port), .out_write(out_write), .out_size(out_size),
    .out_wdata(out_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic        e_valid = 0, e_hit = 0, e_write = 0;
  logic [19:0] e_port = 0;
  logic [1:0]  e_size = 0;
  logic [31:0] e_wdata = 0;
  string       e_tag = "R1";

  function automatic logic [19:0] ref_port(input logic [31:0] a, input logic m);
    longint unsigned v;
    if (a < 32'h8000_0000 || a >= 32'h8080_0000) return 20'h0;
    if (!m) v = a & 32'h0000_FFFF;
    else    v = (a & 32'h1F) | ((a & 32'h07FF_F000) >> 7);
    return 20'(v);
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    chk("R2", "out_valid", out_valid, e_valid);
    chk("R3", "out_hit", out_hit, e_hit);
    chk(e_tag, "out_port", out_port, e_port);
    chk(e_valid ? "R7" : e_tag, "out_size", out_size, e_size);
    chk(e_valid ? "R7" : e_tag, "out_write", out_write, e_write);
    chk(e_valid ? "R7" : e_tag, "out_wdata", out_wdata, e_wdata);
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic w,
                      input logic [1:0] s, input logic [31:0] d, input logic m,
                      input string tag);
    @(negedge clk);
    compare_now();
    in_valid = v; in_addr = a; in_write = w; in_size = s; in_wdata = d; map_mode = m;
    e_valid = v;
    e_hit   = v && a >= 32'h8000_0000 && a < 32'h8080_0000;
    if (v) begin
      e_port = ref_port(a, m); e_size = s; e_write = w; e_wdata = d;
    end
    e_tag = v ? tag : "R8";
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] pa, pb;
    repeat (3) @(negedge clk);
    e_tag = "R1";
    compare_now();                       // R1 during reset
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 0, 0, "R1");        // R1 first cycle after reset
    // R4 contiguous
    step(1, 32'h8000_0398, 1, 0, 32'hA5, 0, "R4");
    step(1, 32'h8001_ABCD, 0, 1, 0, 0, "R4");
    // R5 spread
    step(1, 32'h8000_1234, 1, 2, 32'hDEAD_BEEF, 1, "R5");
    step(1, 32'h807F_F01F, 0, 0, 0, 1, "R5");
    // R6 aliases: differ only in bits 11..5
    step(1, 32'h8000_5003, 0, 0, 0, 1, "R6");
    step(1, 32'h8000_5FE3, 0, 0, 0, 1, "R6");
    pa = ref_port(32'h8000_5003, 1); pb = ref_port(32'h8000_5FE3, 1);
    chk("R6", "alias ports equal", pa, pb);
    // R3 boundaries
    step(1, 32'h807F_FFFF, 0, 2, 1, 0, "R3");
    step(1, 32'h8080_0000, 0, 2, 2, 0, "R3");
    step(1, 32'h7FFF_FFFF, 1, 1, 3, 1, "R3");
    step(1, 32'h8000_0000, 1, 1, 4, 1, "R3");
    // R8 mode flip while idle after request
    step(1, 32'h8000_3044, 1, 0, 32'h55, 1, "R5");
    step(0, 32'h8000_3044, 0, 0, 0, 0, "R8");
    step(0, 32'h1234_5678, 1, 3, 9, 1, "R8");
    step(1, 32'h8000_3044, 0, 0, 0, 0, "R4");
    // R7 random traffic, all sizes, both modes
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom_range(0, 2) != 0) a = 32'h8000_0000 | (a & 32'h007F_FFFF);
      step(($urandom_range(0, 3) != 0), a, 1'($urandom), 2'($urandom_range(0, 2)),
           $urandom, 1'($urandom), "R7");
    end
    step(0, 0, 0, 0, 0, 0, "R8");
    @(negedge clk); compare_now();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule